// File: doc/BRIEF.md
# Software Interrupt Pending Register

This block keeps a word of software-raised interrupt requests for one processor core. It also keeps the processor interrupt level (PIL) threshold. Software reaches both through a small register bus with single-cycle accesses. The pending word can be changed in three ways: a direct store, an alias that ORs the written bits in, and an alias that removes the written bits. The aliases let software raise or drop single requests without a read-modify-write sequence.

From the pending word the block derives the highest pending level. This is the index of the most significant set bit within the level range. Whenever a pending-word update makes that level rise, the block emits a one-cycle recheck pulse so the core looks at its interrupts again. A PIL store always emits the pulse. Accesses to the pending word or its aliases from a non-privileged context are refused with a privilege fault. Addresses outside the map are refused with an illegal-access fault. Interrupt delivery and trap handling are done elsewhere.

Top module: `softint_ctl`

## Requirements
- R1: After reset the pending word and the PIL register are zero, and `acc_fault`, `acc_rdata`, `irq_recheck` and `pend_level` are all zero.
- R2: A privileged write to address 0 loads the low 17 bits of `acc_wdata` into the pending word.
- R3: A privileged write to address 1 makes the pending word equal to its previous value OR the low 17 bits of `acc_wdata`.
- R4: A privileged write to address 2 makes the pending word equal to its previous value AND NOT the low 17 bits of `acc_wdata`.
- R5: An access with `priv_mode` low to address 0, 1 or 2 returns fault code 2'b01, read data zero and no recheck pulse, and leaves the pending word unchanged.
- R6: `pend_level` equals the highest index in 15..1 whose pending bit is set, or 0 when none of those bits is set. Bits 0 and 16 never affect it.
- R7: A successful write to address 0, 1 or 2 pulses `irq_recheck` for exactly one cycle when the new level is above the old level, and does not pulse it otherwise.
- R8: A write to address 3 stores the low 4 bits of `acc_wdata` as PIL and pulses `irq_recheck`, whatever the value of `priv_mode`. Reads of address 3 return PIL and never fault.
- R9: An access to any address from 4 to 7 returns fault code 2'b10 with zero read data and no recheck pulse, and changes no state.
- R10: `acc_rdata`, `acc_fault` and `irq_recheck` are registered and valid in the cycle after the access. A privileged read of address 0 returns the pending word zero-extended, and reads of addresses 1 and 2 return zero. Cycles without an access give all-zero outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_vld | input | 1 | Register access this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 3 | Register address (0 pending, 1 set alias, 2 clear alias, 3 PIL) |
| acc_wdata | input | 32 | Write data |
| priv_mode | input | 1 | Requesting context is privileged |
| acc_rdata | output | 32 | Read data, one cycle after the access |
| acc_fault | output | 2 | 00 none, 01 privilege fault, 10 illegal access |
| irq_recheck | output | 1 | One-cycle request to re-examine interrupts |
| pend_level | output | 4 | Highest pending level in 15..1, 0 if none |

## Verification
The level computation is tried with each single pending bit from 0 to 16. This separates the in-range bits from the two excluded end bits. Every ordered pair of single-bit levels is then written in sequence, so rising, equal and falling transitions each show whether the recheck pulse follows a true rise only. Every address, direction and privilege combination is swept with fixed data patterns, which separates the privilege fault from the illegal fault and the alias reads from the direct read. A long pseudo-random mix of set, clear and direct writes on wide patterns then shows that the OR and AND-NOT updates compose correctly over many steps.

// File: rtl/softint_pkg.sv
// Shared types for the software interrupt pending register.
// Assumes the address map below is fixed; widths come from module parameters.
package softint_pkg;

    typedef enum logic [1:0] {
        FLT_NONE = 2'b00,
        FLT_PRIV = 2'b01,
        FLT_ILL  = 2'b10
    } flt_e;

    typedef enum logic [1:0] {
        POP_NONE,
        POP_LOAD,
        POP_OR,
        POP_ANDN
    } pend_op_e;

    typedef enum logic [1:0] {
        RSEL_NONE,
        RSEL_PEND,
        RSEL_ZERO,
        RSEL_PIL
    } rsel_e;

    localparam int ADDR_PEND = 0;
    localparam int ADDR_SET  = 1;
    localparam int ADDR_CLR  = 2;
    localparam int ADDR_PIL  = 3;

endpackage

// File: rtl/softint_lvl_enc.sv
// Priority encoder: returns the highest set bit index within [LO, HI] of vec,
// or 0 when no bit in that range is set. Assumes 1 <= LO <= HI < PW.
module softint_lvl_enc #(
    parameter int PW = 17,
    parameter int LO = 1,
    parameter int HI = 15,
    parameter int LW = 4
) (
    input  logic [PW-1:0] vec,
    output logic [LW-1:0] lvl
);

    // Scan upward so the last set bit in range wins.
    always_comb begin
        lvl = '0;
        for (int i = LO; i <= HI; i++) begin
            if (vec[i]) lvl = LW'(i);
        end
    end

endmodule

// File: rtl/softint_decode.sv
// Access decoder: turns one bus access into a pending-word operation, a PIL
// store, a read-data selection and a fault code. Unknown addresses take
// precedence over the privilege check; the PIL register has no privilege check.
module softint_decode
    import softint_pkg::*;
#(
    parameter int AW = 3
) (
    input  logic          acc_vld,
    input  logic          acc_wr,
    input  logic [AW-1:0] acc_addr,
    input  logic          priv_mode,
    output pend_op_e      pend_op,
    output logic          pil_wr,
    output rsel_e         rsel,
    output flt_e          flt
);

    logic hit_pend, hit_set, hit_clr, hit_pil, hit_soft;

    // Match the address against the four mapped registers.
    always_comb begin
        hit_pend = (acc_addr == AW'(ADDR_PEND));
        hit_set  = (acc_addr == AW'(ADDR_SET));
        hit_clr  = (acc_addr == AW'(ADDR_CLR));
        hit_pil  = (acc_addr == AW'(ADDR_PIL));
        hit_soft = hit_pend | hit_set | hit_clr;
    end

    // Resolve fault, operation and read selection for the access.
    always_comb begin
        pend_op = POP_NONE;
        pil_wr  = 1'b0;
        rsel    = RSEL_NONE;
        flt     = FLT_NONE;
        if (acc_vld) begin
            if (!(hit_soft | hit_pil)) begin
                flt = FLT_ILL;
            end else if (hit_soft && !priv_mode) begin
                flt = FLT_PRIV;
            end else if (hit_pil) begin
                pil_wr = acc_wr;
                rsel   = acc_wr ? RSEL_NONE : RSEL_PIL;
            end else if (acc_wr) begin
                pend_op = hit_pend ? POP_LOAD : (hit_set ? POP_OR : POP_ANDN);
            end else begin
                rsel = hit_pend ? RSEL_PEND : RSEL_ZERO;
            end
        end
    end

endmodule

// File: rtl/softint_pend_reg.sv
// Pending word storage with direct, OR and AND-NOT update paths.
// Exposes both the next value and the current value so the caller can
// compare levels before and after the update edge.
module softint_pend_reg
    import softint_pkg::*;
#(
    parameter int PW = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  pend_op_e      pend_op,
    input  logic [PW-1:0] wval,
    output logic [PW-1:0] pend_d,
    output logic [PW-1:0] pend_q
);

    // Next-value selection for the three write forms.
    always_comb begin
        unique case (pend_op)
            POP_LOAD: pend_d = wval;
            POP_OR:   pend_d = pend_q | wval;
            POP_ANDN: pend_d = pend_q & ~wval;
            default:  pend_d = pend_q;
        endcase
    end

    // Hold the pending word; synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

endmodule

// File: rtl/softint_ctl.sv
// Software interrupt pending register with set and clear aliases plus a PIL
// register. Accesses are single-cycle; read data, fault and the recheck pulse
// are registered and appear in the cycle after the access.
// Assumes PW <= DW and PIL_W <= DW.
module softint_ctl
    import softint_pkg::*;
#(
    parameter int DW     = 32,
    parameter int AW     = 3,
    parameter int PW     = 17,
    parameter int LVL_LO = 1,
    parameter int LVL_HI = 15,
    parameter int PIL_W  = 4,
    localparam int LW    = $clog2(LVL_HI + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_vld,
    input  logic          acc_wr,
    input  logic [AW-1:0] acc_addr,
    input  logic [DW-1:0] acc_wdata,
    input  logic          priv_mode,
    output logic [DW-1:0] acc_rdata,
    output logic [1:0]    acc_fault,
    output logic          irq_recheck,
    output logic [LW-1:0] pend_level
);

    pend_op_e         pend_op;
    logic             pil_wr;
    rsel_e            rsel;
    flt_e             flt;
    logic [PW-1:0]    pend_d, pend_q;
    logic [LW-1:0]    lvl_new, lvl_old;
    logic [PIL_W-1:0] pil_q;
    logic [DW-1:0]    rdata_d;
    logic             rise;

    softint_decode #(.AW(AW)) u_dec (
        .acc_vld  (acc_vld),
        .acc_wr   (acc_wr),
        .acc_addr (acc_addr),
        .priv_mode(priv_mode),
        .pend_op  (pend_op),
        .pil_wr   (pil_wr),
        .rsel     (rsel),
        .flt      (flt)
    );

    softint_pend_reg #(.PW(PW)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend_op(pend_op),
        .wval   (acc_wdata[PW-1:0]),
        .pend_d (pend_d),
        .pend_q (pend_q)
    );

    softint_lvl_enc #(.PW(PW), .LO(LVL_LO), .HI(LVL_HI), .LW(LW)) u_enc_old (
        .vec(pend_q),
        .lvl(lvl_old)
    );

    softint_lvl_enc #(.PW(PW), .LO(LVL_LO), .HI(LVL_HI), .LW(LW)) u_enc_new (
        .vec(pend_d),
        .lvl(lvl_new)
    );

    assign pend_level = lvl_old;

    // Flag a level rise caused by a pending-word write.
    always_comb rise = (pend_op != POP_NONE) && (lvl_new > lvl_old);

    // Select read data for the current access.
    always_comb begin
        unique case (rsel)
            RSEL_PEND: rdata_d = DW'(pend_q);
            RSEL_PIL:  rdata_d = DW'(pil_q);
            default:   rdata_d = '0;
        endcase
    end

    // Hold the PIL threshold.
    always_ff @(posedge clk) begin
        if (!rst_n)      pil_q <= '0;
        else if (pil_wr) pil_q <= acc_wdata[PIL_W-1:0];
    end

    // Register the access response and the recheck pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_rdata   <= '0;
            acc_fault   <= FLT_NONE;
            irq_recheck <= 1'b0;
        end else begin
            acc_rdata   <= rdata_d;
            acc_fault   <= flt;
            irq_recheck <= rise | pil_wr;
        end
    end

endmodule

// File: rtl/softint_ctl_chk.sv
// Property checker for softint_ctl, attached by bind. Looks only at ports and
// the stored pending word.
module softint_ctl_chk #(
    parameter int DW = 32,
    parameter int AW = 3,
    parameter int PW = 17,
    parameter int LW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          acc_vld,
    input logic          acc_wr,
    input logic [AW-1:0] acc_addr,
    input logic          priv_mode,
    input logic [DW-1:0] acc_rdata,
    input logic [1:0]    acc_fault,
    input logic          irq_recheck,
    input logic [LW-1:0] pend_level,
    input logic [PW-1:0] pend_q
);

    // R7
    rise_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_recheck && !$past(acc_vld && acc_wr && acc_addr == AW'(3)))
            |-> (pend_level > $past(pend_level)));

    // R5
    priv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_fault == 2'b01) |-> ($stable(pend_q) && !irq_recheck && acc_rdata == '0));

    // R9
    illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_fault == 2'b10) |-> ($stable(pend_q) && !irq_recheck && acc_rdata == '0));

    // R5
    user_soft_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_vld && !priv_mode && acc_addr < AW'(3)) |=> (acc_fault == 2'b01));

    // R10
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_vld |=> (acc_fault == 2'b00 && !irq_recheck && acc_rdata == '0));

    // R6
    level_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_level != '0) |-> pend_q[pend_level]);

endmodule

bind softint_ctl softint_ctl_chk #(.DW(DW), .AW(AW), .PW(PW), .LW(LW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_vld    (acc_vld),
    .acc_wr     (acc_wr),
    .acc_addr   (acc_addr),
    .priv_mode  (priv_mode),
    .acc_rdata  (acc_rdata),
    .acc_fault  (acc_fault),
    .irq_recheck(irq_recheck),
    .pend_level (pend_level),
    .pend_q     (pend_q)
);

// File: tb/softint_ctl_bench.sv
`timescale 1ns/1ps
module softint_ctl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_vld = 1'b0;
    logic        acc_wr = 1'b0;
    logic [2:0]  acc_addr = '0;
    logic [31:0] acc_wdata = '0;
    logic        priv_mode = 1'b0;
    logic [31:0] acc_rdata;
    logic [1:0]  acc_fault;
    logic        irq_recheck;
    logic [3:0]  pend_level;

    int n_chk = 0;
    int n_bad = 0;
    logic [16:0] m_pend = '0;
    logic [3:0]  m_pil = '0;
    logic [31:0] lfsr = 32'h1ACE_B00C;

    always #4 clk = ~clk;

    softint_ctl u_softint_ctl (
        .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_wr(acc_wr),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .priv_mode(priv_mode),
        .acc_rdata(acc_rdata), .acc_fault(acc_fault),
        .irq_recheck(irq_recheck), .pend_level(pend_level)
    );

    function automatic int lvl_of(logic [16:0] v);
        int l = 0;
        for (int i = 1; i <= 15; i++) if (v[i]) l = i;
        return l;
    endfunction

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // One access, checked against the bench model one cycle later.
    task automatic access(logic p, logic w, logic [2:0] a, logic [31:0] d);
        logic [1:0]  e_flt = 2'b00;
        logic [31:0] e_rd = '0;
        logic        e_chk = 1'b0;
        logic [16:0] nxt = m_pend;
        string       tag;
        if (a > 3'd3) begin
            e_flt = 2'b10; tag = "R9";
        end else if (a != 3'd3 && !p) begin
            e_flt = 2'b01; tag = "R5";
        end else if (a == 3'd3) begin
            tag = "R8";
            if (w) begin m_pil = d[3:0]; e_chk = 1'b1; end
            else e_rd = {28'd0, m_pil};
        end else if (w) begin
            case (a)
                3'd0: begin nxt = d[16:0]; tag = "R2"; end
                3'd1: begin nxt = m_pend | d[16:0]; tag = "R3"; end
                default: begin nxt = m_pend & ~d[16:0]; tag = "R4"; end
            endcase
            e_chk = lvl_of(nxt) > lvl_of(m_pend);
            m_pend = nxt;
        end else begin
            tag = "R10";
            e_rd = (a == 3'd0) ? {15'd0, m_pend} : 32'd0;
        end
        acc_vld = 1'b1; acc_wr = w; acc_addr = a; acc_wdata = d; priv_mode = p;
        @(posedge clk);
        @(negedge clk);
        acc_vld = 1'b0;
        check(tag, "fault", {30'd0, acc_fault}, {30'd0, e_flt});
        check(tag, "rdata", acc_rdata, e_rd);
        check("R7", "recheck", {31'd0, irq_recheck}, {31'd0, e_chk});
        check("R6", "level", {28'd0, pend_level}, 32'(lvl_of(m_pend)));
    endtask

    // Confirm stored pending word through a privileged direct read.
    task automatic readback(string tag);
        access(1'b1, 1'b0, 3'd0, 32'd0);
        check(tag, "readback", acc_rdata, {15'd0, m_pend});
    endtask

    initial begin
        #(200000 * 8);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1", "fault", {30'd0, acc_fault}, 32'd0);
        check("R1", "rdata", acc_rdata, 32'd0);
        check("R1", "recheck", {31'd0, irq_recheck}, 32'd0);
        check("R1", "level", {28'd0, pend_level}, 32'd0);
        readback("R1");
        access(1'b1, 1'b0, 3'd3, 32'd0);
        check("R1", "pil", acc_rdata, 32'd0);

        // R6 every single bit, including excluded bits 0 and 16
        for (int b = 0; b < 17; b++) begin
            access(1'b1, 1'b1, 3'd0, 32'(1) << b);
            check("R6", "single", {28'd0, pend_level}, (b >= 1 && b <= 15) ? 32'(b) : 32'd0);
        end

        // R7 every ordered pair of levels
        for (int a = 0; a < 17; a++) begin
            for (int b = 0; b < 17; b++) begin
                access(1'b1, 1'b1, 3'd0, 32'(1) << a);
                access(1'b1, 1'b1, 3'd0, 32'(1) << b);
            end
        end

        // Sweep every address, direction and privilege with patterns (R5, R8, R9, R10)
        for (int k = 0; k < 4; k++) begin
            for (int a = 0; a < 8; a++) begin
                for (int p = 0; p < 2; p++) begin
                    for (int w = 0; w < 2; w++) begin
                        logic [31:0] pat;
                        case (k)
                            0: pat = 32'hFFFF_FFFF;
                            1: pat = 32'h0001_5555;
                            2: pat = 32'h0000_AAAA;
                            default: pat = 32'h0000_8001;
                        endcase
                        access(p[0], w[0], a[2:0], pat);
                        readback(p[0] ? "R10" : "R5");
                    end
                end
            end
        end

        // R3 / R4 set and clear bring-up of single levels
        access(1'b1, 1'b1, 3'd0, 32'd0);
        access(1'b1, 1'b1, 3'd1, 32'h0000_0010);
        check("R3", "set", {28'd0, pend_level}, 32'd4);
        access(1'b1, 1'b1, 3'd1, 32'h0001_0001);
        check("R3", "set-ends", {28'd0, pend_level}, 32'd4);
        access(1'b1, 1'b1, 3'd2, 32'h0000_0010);
        check("R4", "clear", {28'd0, pend_level}, 32'd0);
        readback("R4");

        // Pseudo-random mix of all access kinds (R2, R3, R4, R7, R8)
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            access(lfsr[31] | lfsr[30], lfsr[29] | lfsr[28], {1'b0, lfsr[27:26]},
                   {lfsr[7:0], lfsr[25:2]});
        end
        readback("R2");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule